// File: doc/BRIEF.md
# Timed Multi-Pattern LED Sequencer

This block drives a bank of eight LEDs through three light patterns that follow each other on a fixed dwell timer: a single lit position walking toward the most significant bit, the whole bank blinking off and on, and a single lit position walking toward the least significant bit. The LED vector only moves on a beat. The beat runs at one of two rates, a quarter second or half a second, and a one-cycle pulse on the rate input switches between them.

All timing comes from one counter that divides the system clock into quarter-second enables. No derived clocks are used. From those enables the block builds the beat and a one-second tick. The one-second tick counts down the time left in the current pattern. The pattern number and the seconds remaining are brought out for an external display driver. Seven-segment encoding and button debouncing are handled by other logic.

Top module: `led_pattern_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `led` is 8'h01, `pat_num` is 1, `secs_left` is 19, and the beat rate is the slow one.
- R2: One quarter tick is CLK_HZ/4 clock cycles long, and the first one ends CLK_HZ/4 cycles after reset is released. The slow beat falls on every second quarter tick and the fast beat falls on every quarter tick. `led` changes only on a beat.
- R3: Each cycle with `rate_btn` high toggles the requested rate. The beat logic adopts the new rate at the next beat. A toggle has no effect on `secs_left` or `pat_num`.
- R4: Pattern 1 (left walk): `led` has only bit `pos` set. `pos` starts at 0 and steps up by one on each beat, wrapping from 7 to 0.
- R5: Pattern 3 (right walk): `led` has only bit 7-`pos` set, so the lit bit starts at bit 7 and moves down by one on each beat.
- R6: Pattern 2 (flash): `led` is 8'h00 when `pos` is even and 8'hFF when `pos` is odd, so the bank starts dark and alternates on each beat.
- R7: A seconds tick falls on every fourth quarter tick. On a seconds tick, `secs_left` drops by one. When it is already 0, it reloads to 19 instead. It never leaves the range 0 to 19.
- R8: A seconds tick that reloads `secs_left` also moves `pat_num` along the order 1, 2, 3, 1. `pat_num` changes at no other time.
- R9: When the pattern changes, `pos` restarts at 0, so the new pattern shows its first step on that same beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_btn | input | 1 | One-cycle pulse that toggles the beat rate |
| led | output | 8 | LED drive, active high |
| pat_num | output | 2 | Current pattern number, 1 to 3 |
| secs_left | output | 5 | Seconds remaining in the current pattern, 19 down to 0 |

## Verification
The bench places rate toggles at random, including presses that land on a beat edge. A design that adopted the new rate immediately, instead of at the following beat, would shift the beat phase by a quarter second. Its LED stream would then drift away from the model. The runs cover several full rotations, which exercises the reload from 0 to 19, the wrap of `pat_num` from 3 back to 1, and the restart of the step index. A missed restart would show up as a flash pattern that starts lit, or as a walk that starts mid-bank. A reset applied in the middle of a run checks that every piece of timing state returns to its initial value, including a pending fast-rate request.

// File: rtl/led_pattern_seq.sv
module led_pattern_seq #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int N_LED   = 8,
  parameter int DWELL_S = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rate_btn,
  output logic [N_LED-1:0]           led,
  output logic [1:0]                 pat_num,
  output logic [$clog2(DWELL_S)-1:0] secs_left
);
  localparam int QDIV = CLK_HZ / 4;
  localparam int DW   = (QDIV > 2) ? $clog2(QDIV) : 1;
  localparam int PW   = $clog2(N_LED);
  localparam int SW   = $clog2(DWELL_S);

  logic [DW-1:0] div_cnt;
  logic [1:0]    qcnt;
  logic          rate_req, rate_fast;
  logic [PW-1:0] pos;
  logic [1:0]    pat;
  logic          qtick, sec_tick, beat, advance;

  assign qtick    = div_cnt == DW'(QDIV - 1);
  assign sec_tick = qtick && (qcnt == 2'd3);
  assign beat     = qtick && (rate_fast || qcnt[0]);
  assign advance  = sec_tick && (secs_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      qcnt      <= '0;
      rate_req  <= 1'b0;
      rate_fast <= 1'b0;
      pos       <= '0;
      pat       <= 2'd0;
      secs_left <= SW'(DWELL_S - 1);
    end else begin
      div_cnt  <= qtick ? '0 : div_cnt + 1'b1;
      if (qtick) qcnt <= qcnt + 2'd1;
      rate_req <= rate_req ^ rate_btn;
      if (beat) rate_fast <= rate_req;
      if (sec_tick) secs_left <= advance ? SW'(DWELL_S - 1) : secs_left - 1'b1;
      if (advance) pat <= (pat == 2'd2) ? 2'd0 : pat + 2'd1;
      if (advance) pos <= '0;
      else if (beat) pos <= (pos == PW'(N_LED - 1)) ? '0 : pos + 1'b1;
    end
  end

  always_comb begin
    case (pat)
      2'd0:    led = N_LED'(1) << pos;
      2'd1:    led = {N_LED{pos[0]}};
      default: led = N_LED'(1) << (PW'(N_LED - 1) - pos);
    endcase
  end

  assign pat_num = pat + 2'd1;

  p_led_beat_only_r2: assert property (@(posedge clk) disable iff (rst)
    !beat |=> $stable(led));
  p_walk_single_r4: assert property (@(posedge clk) disable iff (rst)
    (pat_num != 2'd2) |-> $countones(led) == 1);
  p_cd_range_r7: assert property (@(posedge clk) disable iff (rst)
    secs_left <= SW'(DWELL_S - 1));
  p_cd_step_r7: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && secs_left != '0) |=> secs_left == $past(secs_left) - 1'b1);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> ($stable(secs_left) && $stable(pat_num)));
  p_rotate_r8: assert property (@(posedge clk) disable iff (rst)
    advance |=> (pat_num != $past(pat_num) && secs_left == SW'(DWELL_S - 1)));
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    advance |=> pos == '0);
endmodule

// File: tb/led_pattern_seq_tb.sv
module led_pattern_seq_tb;
  localparam int HZ = 40;
  localparam int Q  = HZ / 4;

  logic       clk = 0, rst = 1, rate_btn = 0;
  logic [7:0] led;
  logic [1:0] pat_num;
  logic [4:0] secs_left;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  led_pattern_seq #(.CLK_HZ(HZ), .N_LED(8), .DWELL_S(20)) u_dut (
    .clk(clk), .rst(rst), .rate_btn(rate_btn),
    .led(led), .pat_num(pat_num), .secs_left(secs_left));

  always #10 clk = ~clk;

  int m_t, m_cd, m_pat, m_pos;
  bit m_req, m_act, m_beat, m_adv;

  function automatic logic [7:0] exp_led(int p, int s);
    if (p == 1) return 8'h01 << s;
    if (p == 2) return (s % 2) ? 8'hFF : 8'h00;
    return 8'h80 >> s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_t = 0; m_cd = 19; m_pat = 1; m_pos = 0;
      m_req = 0; m_act = 0; m_beat = 0; m_adv = 0;
    end else begin
      bit qt, st;
      int qidx;
      qt   = ((m_t + 1) % Q) == 0;
      qidx = (m_t + 1) / Q;
      st   = qt && (qidx % 4 == 0);
      m_beat = qt && (m_act || (qidx % 2 == 0));
      m_adv  = st && (m_cd == 0);
      if (m_beat) m_act = m_req;
      if (rate_btn) m_req = !m_req;
      if (st) m_cd = m_adv ? 19 : m_cd - 1;
      if (m_adv) begin
        m_pat = (m_pat == 3) ? 1 : m_pat + 1;
        m_pos = 0;
      end else if (m_beat) m_pos = (m_pos + 1) % 8;
      m_t++;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [7:0] e;
      string tag;
      e = exp_led(m_pat, m_pos);
      if (m_adv) tag = "R9";
      else if (!m_beat) tag = "R2";
      else if (m_act) tag = "R3";
      else if (m_pat == 1) tag = "R4";
      else if (m_pat == 2) tag = "R6";
      else tag = "R5";
      chk(led == e, tag, led, e);
      chk(int'(pat_num) == m_pat, "R8", pat_num, m_pat);
      chk(int'(secs_left) == m_cd, "R7", secs_left, m_cd);
    end
  end

  task automatic check_reset_state(string tag);
    chk(led == 8'h01, tag, led, 8'h01);
    chk(pat_num == 2'd1, tag, pat_num, 1);
    chk(secs_left == 5'd19, tag, secs_left, 19);
  endtask

  task automatic run(int n, int force_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rate_btn = (i == force_at) || ($urandom % 150 == 0);
    end
    @(negedge clk);
    rate_btn = 0;
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst = 0;
    @(negedge clk);
    check_reset_state("R1");
    run(5200, 50);
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    check_reset_state("R1");
    rst = 0;
    run(2600, 2 * Q - 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule